// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath in which one memory, one ALU and one register file are shared across the steps of an instruction. It is a Moore state machine. It walks every instruction through a common fetch step and a common decode/register-read step. From there it takes one of four paths, by instruction class: memory reference, register-register arithmetic, conditional branch or unconditional jump. Each path has its own execute, memory and write-back steps. Every path ends by returning to fetch.

The sixteen datapath control lines are a function of the state alone, and they are driven from flip-flops. The opcode steers only the choice of the next state. Loads take five cycles, stores and register-register operations take four, and branches and jumps take three. An opcode outside the five supported ones leaves decode and goes straight back to fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the outputs after that edge are the fetch-step values of R2.
- R2: Fetch step: mem_read=1, addr_sel=0, ir_load=1, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src_sel=00, pc_load=1, and every other output 0.
- R3: The step after fetch is always decode, for any opcode: alu_a_sel=0, alu_b_sel=11, alu_op=00, and every other output 0.
- R4: The opcode is sampled in decode and chooses the path. Load is 6'h23, store is 6'h2B, register-register is 6'h00, branch is 6'h04 and jump is 6'h02. Counted from one fetch to the next, the lengths are load 5, store 4, register-register 4, branch 3 and jump 3 cycles.
- R5: Address step (load and store): alu_a_sel=1, alu_b_sel=10, alu_op=00, and every other output 0.
- R6: A load continues with a read step (mem_read=1, addr_sel=1, others 0). It then has a write-back step (reg_write=1, wb_sel=1, dst_sel=0, others 0).
- R7: Store access step: mem_write=1, addr_sel=1, and every other output 0.
- R8: Register-register execute step: alu_a_sel=1, alu_b_sel=00, alu_op=10, others 0. It is followed by a completion step: reg_write=1, dst_sel=1, wb_sel=0, others 0.
- R9: Branch step: alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_load_cond=1, pc_src_sel=01, and every other output 0.
- R10: Jump step: pc_load=1, pc_src_sel=10, and every other output 0.
- R11: Any opcode outside the five of R4, seen in decode, returns the machine to fetch on the next edge.
- R12: The opcode is sampled only in the decode step and the address step. In the address step the load opcode selects the read step, and any other value selects the store access step. Opcode changes in all other steps have no effect on outputs or sequencing.
- R13: mem_read and mem_write are never both 1, and pc_load and pc_load_cond are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to fetch |
| opcode | input | 6 | Opcode field of the held instruction |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ir_load | output | 1 | Instruction register load |
| reg_write | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU result register, 1 memory data register |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU function: 00 add, 01 subtract, 10 from function field |
| pc_src_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_cond | output | 1 | PC write when ALU reports zero |

## Verification
Each supported opcode is first sent through a full instruction, with the whole output vector compared in every cycle. A reserved opcode is then sent, which separates the five dispatch paths from the fall-back to fetch. A long random run follows. It mixes the five classes, unsupported opcodes, occasional mid-instruction resets and random opcode noise in the steps that must ignore the opcode. A wrongly decoded opcode, a wrong step length, a wrong output bit or a sequencer that reacts to the noise each shows up as a vector or length mismatch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W  = 4;
  localparam int OPC_W = 6;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MREAD  = 4'd3,
    ST_LWB    = 4'd4,
    ST_MWRITE = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_t;

  typedef struct packed {
    logic       mem_read;
    logic       mem_write;
    logic       addr_sel;
    logic       ir_load;
    logic       reg_write;
    logic       dst_sel;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src_sel;
    logic       pc_load;
    logic       pc_load_cond;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OPC_W-1:0] OP_RR    = 6'h00,
  parameter logic [OPC_W-1:0] OP_BR    = 6'h04,
  parameter logic [OPC_W-1:0] OP_JMP   = 6'h02
) (
  input  step_t             cur,
  input  logic [OPC_W-1:0]  opcode,
  output step_t             nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_MADDR;
        else if (opcode == OP_RR)                    nxt = ST_REXEC;
        else if (opcode == OP_BR)                    nxt = ST_BRANCH;
        else if (opcode == OP_JMP)                   nxt = ST_JUMP;
        else                                         nxt = ST_FETCH;
      end
      ST_MADDR:  nxt = (opcode == OP_LOAD) ? ST_MREAD : ST_MWRITE;
      ST_MREAD:  nxt = ST_LWB;
      ST_REXEC:  nxt = ST_RDONE;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  step_t st,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    unique case (st)
      ST_FETCH: begin
        ctl.mem_read  = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.alu_b_sel = 2'b01;
        ctl.pc_load   = 1'b1;
      end
      ST_DECODE: ctl.alu_b_sel = 2'b11;
      ST_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      ST_MREAD: begin
        ctl.mem_read = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LWB: begin
        ctl.reg_write = 1'b1;
        ctl.wb_sel    = 1'b1;
      end
      ST_MWRITE: begin
        ctl.mem_write = 1'b1;
        ctl.addr_sel  = 1'b1;
      end
      ST_REXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = 2'b10;
      end
      ST_RDONE: begin
        ctl.reg_write = 1'b1;
        ctl.dst_sel   = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel    = 1'b1;
        ctl.alu_op       = 2'b01;
        ctl.pc_src_sel   = 2'b01;
        ctl.pc_load_cond = 1'b1;
      end
      ST_JUMP: begin
        ctl.pc_src_sel = 2'b10;
        ctl.pc_load    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OPC_W-1:0] OP_RR    = 6'h00,
  parameter logic [OPC_W-1:0] OP_BR    = 6'h04,
  parameter logic [OPC_W-1:0] OP_JMP   = 6'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             mem_read,
  output logic             mem_write,
  output logic             addr_sel,
  output logic             ir_load,
  output logic             reg_write,
  output logic             dst_sel,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src_sel,
  output logic             pc_load,
  output logic             pc_load_cond
);

  step_t state_q;
  step_t state_d;
  step_t state_step;
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  mc_ctrl_next #(
    .OP_LOAD (OP_LOAD),
    .OP_STORE(OP_STORE),
    .OP_RR   (OP_RR),
    .OP_BR   (OP_BR),
    .OP_JMP  (OP_JMP)
  ) u_next (
    .cur   (state_q),
    .opcode(opcode),
    .nxt   (state_step)
  );

  // Reset folds into the next-state path so one decoder serves both.
  assign state_d = rst ? ST_FETCH : state_step;

  // Outputs are decoded from the next state and registered beside it,
  // so they reflect the current state without a decode stage after the flops.
  mc_ctrl_decode u_dec (
    .st (state_d),
    .ctl(ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctrl_q  <= ctrl_d;
  end

  assign mem_read     = ctrl_q.mem_read;
  assign mem_write    = ctrl_q.mem_write;
  assign addr_sel     = ctrl_q.addr_sel;
  assign ir_load      = ctrl_q.ir_load;
  assign reg_write    = ctrl_q.reg_write;
  assign dst_sel      = ctrl_q.dst_sel;
  assign wb_sel       = ctrl_q.wb_sel;
  assign alu_a_sel    = ctrl_q.alu_a_sel;
  assign alu_b_sel    = ctrl_q.alu_b_sel;
  assign alu_op       = ctrl_q.alu_op;
  assign pc_src_sel   = ctrl_q.pc_src_sel;
  assign pc_load      = ctrl_q.pc_load;
  assign pc_load_cond = ctrl_q.pc_load_cond;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk #(
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B,
  parameter logic [5:0] OP_RR    = 6'h00,
  parameter logic [5:0] OP_BR    = 6'h04,
  parameter logic [5:0] OP_JMP   = 6'h02
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       mem_read,
  input logic       mem_write,
  input logic       addr_sel,
  input logic       ir_load,
  input logic       reg_write,
  input logic       dst_sel,
  input logic       wb_sel,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src_sel,
  input logic       pc_load,
  input logic       pc_load_cond
);

  logic known_op;
  assign known_op = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                    (opcode == OP_RR) || (opcode == OP_BR) || (opcode == OP_JMP);

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (mem_read && ir_load && pc_load && !mem_write));

  p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11 && !ir_load && !pc_load));

  p_load_read_to_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_read && addr_sel) |=> (reg_write && wb_sel && !dst_sel));

  p_store_returns_r7: assert property (@(posedge clk) disable iff (rst)
    mem_write |=> ir_load);

  p_rr_exec_to_done_r8: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b10) |=> (reg_write && dst_sel && !wb_sel));

  p_branch_returns_r9: assert property (@(posedge clk) disable iff (rst)
    pc_load_cond |=> ir_load);

  p_jump_returns_r10: assert property (@(posedge clk) disable iff (rst)
    (pc_src_sel == 2'b10) |=> ir_load);

  p_unknown_to_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    (alu_b_sel == 2'b11 && !known_op) |=> ir_load);

  p_mem_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  p_pc_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(pc_load && pc_load_cond));

endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
  .OP_LOAD (OP_LOAD),
  .OP_STORE(OP_STORE),
  .OP_RR   (OP_RR),
  .OP_BR   (OP_BR),
  .OP_JMP  (OP_JMP)
) u_chk (.*);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;

  localparam int PERIOD = 10;
  localparam logic [5:0] OPL = 6'h23, OPS = 6'h2B, OPR = 6'h00, OPB = 6'h04, OPJ = 6'h02;
  localparam int F = 0, D = 1, MA = 2, MR = 3, LW = 4, MW = 5, RX = 6, RD = 7, BR = 8, JP = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic mem_read, mem_write, addr_sel, ir_load, reg_write, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src_sel;
  logic pc_load, pc_load_cond;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_read(mem_read), .mem_write(mem_write), .addr_sel(addr_sel), .ir_load(ir_load),
    .reg_write(reg_write), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src_sel(pc_src_sel),
    .pc_load(pc_load), .pc_load_cond(pc_load_cond)
  );

  // Vector order: rd wr addr ir regw dst wb a b[2] op[2] pcsrc[2] pcw pcc
  function automatic logic [15:0] exp_ctrl(int s);
    case (s)
      F:  return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b1,1'b0};
      D:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,1'b0};
      MA: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0};
      MR: return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
      LW: return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
      MW: return {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
      RX: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0};
      RD: return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
      BR: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,2'b01,1'b0,1'b1};
      default: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b1,1'b0};
    endcase
  endfunction

  function automatic int exp_next(int s, logic [5:0] op);
    case (s)
      F: return D;
      D: begin
        if (op == OPL || op == OPS) return MA;
        if (op == OPR) return RX;
        if (op == OPB) return BR;
        if (op == OPJ) return JP;
        return F;
      end
      MA: return (op == OPL) ? MR : MW;
      MR: return LW;
      RX: return RD;
      default: return F;
    endcase
  endfunction

  function automatic int exp_len(logic [5:0] op);
    if (op == OPL) return 5;
    if (op == OPS || op == OPR) return 4;
    if (op == OPB || op == OPJ) return 3;
    return 2;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      F: return "R2";
      D: return "R3";
      MA: return "R5";
      MR, LW: return "R6";
      MW: return "R7";
      RX, RD: return "R8";
      BR: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [5:0] pick_class(int k);
    logic [5:0] u;
    case (k)
      0: return OPL;
      1: return OPS;
      2: return OPR;
      3: return OPB;
      4: return OPJ;
      default: begin
        u = 6'($urandom);
        while (u == OPL || u == OPS || u == OPR || u == OPB || u == OPJ) u = u + 6'd1;
        return u;
      end
    endcase
  endfunction

  logic [15:0] act;
  assign act = {mem_read, mem_write, addr_sel, ir_load, reg_write, dst_sel, wb_sel, alu_a_sel,
                alu_b_sel, alu_op, pc_src_sel, pc_load, pc_load_cond};

  initial begin
    int ms;
    int cyc;
    bit len_ok;
    bit after_rst;
    bit noise;
    bit noisy_instr;
    logic [5:0] cls;
    logic [5:0] held;
    int nseq;
    string tg;
    void'($urandom(32'h5EED_0071));
    ms = F; cyc = 0; len_ok = 0; after_rst = 0; noise = 0; noisy_instr = 0;
    cls = OPR; held = OPR; nseq = 0;
    // Reset for two edges.
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    ms = F;
    after_rst = 1;
    @(negedge clk);
    for (int step = 0; step < 4000; step++) begin
      // Check the full vector for the modelled state.
      tg = after_rst ? "R1" : tag_of(ms);
      checks++;
      if (act !== exp_ctrl(ms)) begin
        fails++;
        $display("FAIL %s state=%0d actual=%b expected=%b", tg, ms, act, exp_ctrl(ms));
      end
      if (ms == F && len_ok) begin
        checks++;
        if (cyc != exp_len(cls)) begin
          fails++;
          $display("FAIL %s length actual=%0d expected=%0d op=%h",
                   (exp_len(cls) == 2) ? "R11" : (noisy_instr ? "R12" : "R4"),
                   cyc, exp_len(cls), cls);
        end
      end
      if (ms == F) begin
        cyc = 1;
        len_ok = !after_rst || 1'b1;
        noisy_instr = noise;
      end else cyc++;
      after_rst = 0;
      // Choose stimulus for the next edge.
      noise = (step > 60);
      if (step > 60 && ($urandom % 50) == 0) begin
        rst = 1'b1;
      end else begin
        rst = 1'b0;
      end
      if (ms == D) begin
        if (nseq < 6) cls = pick_class(nseq);
        else cls = pick_class(($urandom % 7 == 0) ? 5 : int'($urandom % 5));
        nseq++;
        held = cls;
        opcode = held;
      end else if (ms == MA) begin
        opcode = held;
      end else if (noise) begin
        opcode = 6'($urandom);
      end else begin
        opcode = held;
      end
      @(posedge clk); #1;
      if (rst) begin
        ms = F;
        after_rst = 1;
        len_ok = 0;
      end else begin
        ms = exp_next(ms, opcode);
      end
      rst = 1'b0;
      @(negedge clk);
      if (after_rst) len_ok = 0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule